// File: doc/BRIEF.md
# TRNG-steered multi-polynomial LFSR

This block is a 16-bit pseudorandom word generator for small tags and sensor nodes. A 16-bit shift register moves one position per enabled cycle. Its feedback bit is the parity of the register under one of eight fixed tap masks. The active mask is picked by a wheel pointer. Every `ROT_PERIOD` shifts the pointer may advance by one or two slots, as the external true-random bit of that cycle decides. Because every step is nonzero and smaller than the wheel, two consecutive selections never use the same polynomial.

A second mode keeps the wheel still and mixes the entropy bit straight into the register's input cell on every shift. Sixteen shifts make up one output word. The word is latched and announced with a one-cycle valid pulse. Software or a neighbouring state machine loads a seed, raises `run`, and collects a word every sixteen enabled cycles.

Top module: `trng_mp_lfsr`

## Requirements
- R1: After reset the register holds 0xACE1, the wheel sits at slot 0, the shift and rotation counters are 0, `word_out` is 0 and `word_valid` is 0.
- R2: When `seed_load` is high, the register takes `seed`, or 0xACE1 when `seed` is zero. The wheel, the shift counter and the rotation counter return to 0, and no shift occurs even if `run` is high.
- R3: On each cycle with `run` high and `seed_load` low, the register becomes {reg[14:0], f}. Here f is the parity of (reg AND mask[slot]), XORed with the injected bit of R9. The masks for slots 0..7 are 0xB400, 0xD008, 0x8016, 0x8805, 0x801C, 0x9C00, 0x8068 and 0x8B00.
- R4: On the 16th shift since reset or load, and on every 16th shift after that, `word_out` takes the register value after that shift, and `word_valid` is high for exactly the cycle that follows. `word_out` keeps its value between words.
- R5: With `run` low and `seed_load` low, the register, the wheel and both counters hold, and `word_valid` is low.
- R6: A rotation falls due on every `ROT_PERIOD`-th shift. The shift on which it falls due still uses the old slot, and the new slot applies from the next shift on.
- R7: At a rotation that falls due in wheel mode (`mode_inject` low) with `trng_valid` high, the slot advances by 2 when `trng_bit` is 1 and by 1 when it is 0, modulo 8. The new slot therefore always differs from the old one.
- R8: When `trng_valid` is low at a rotation that falls due, the wheel holds its slot, and the rotation slot is still used up.
- R9: With `mode_inject` high, the wheel never moves, and the input cell receives f XOR (`trng_bit` AND `trng_valid`) on every shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed` and restart counters and wheel |
| seed | input | 16 | Seed value (zero is replaced by 0xACE1) |
| trng_bit | input | 1 | External true-random bit |
| trng_valid | input | 1 | `trng_bit` carries a fresh value |
| run | input | 1 | Shift enable |
| mode_inject | input | 1 | 1: inject entropy into input cell; 0: wheel mode |
| word_out | output | 16 | Last assembled word |
| word_valid | output | 1 | One-cycle pulse when `word_out` is new |

## Verification
On every cycle, the bound checker keeps its own shift and rotation counters. With them it checks the word cadence, that the wheel holds when idle or when entropy is missing, that each rotation moves by the step the entropy bit asks for and never repeats a slot, and that a load seeds the register correctly. The actual word values depend on the whole tap and entropy history. Only the bench's reference model can show them, by comparing each word for seeded, zero-seeded, idle-gapped, entropy-starved and injection-mode runs.

// File: rtl/trng_mp_lfsr.sv
module trng_mp_lfsr #(
  parameter int          ROT_PERIOD    = 4,
  parameter logic [15:0] SEED_FALLBACK = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [15:0] seed,
  input  logic        trng_bit,
  input  logic        trng_valid,
  input  logic        run,
  input  logic        mode_inject,
  output logic [15:0] word_out,
  output logic        word_valid
);
  localparam int RCW = (ROT_PERIOD > 1) ? $clog2(ROT_PERIOD) : 1;
  localparam logic [RCW-1:0] RC_LAST = RCW'(ROT_PERIOD - 1);

  function automatic logic [15:0] tap_mask(input logic [2:0] idx);
    case (idx)
      3'd0: return 16'hB400;
      3'd1: return 16'hD008;
      3'd2: return 16'h8016;
      3'd3: return 16'h8805;
      3'd4: return 16'h801C;
      3'd5: return 16'h9C00;
      3'd6: return 16'h8068;
      default: return 16'h8B00;
    endcase
  endfunction

  logic [15:0]    state_q;
  logic [2:0]     pos_q;
  logic [RCW-1:0] rcnt_q;
  logic [3:0]     scnt_q;

  wire        shift_en = run & ~seed_load;
  wire        fb       = ^(state_q & tap_mask(pos_q));
  wire        inj      = mode_inject & trng_valid & trng_bit;
  wire [15:0] state_nx = {state_q[14:0], fb ^ inj};
  wire        rot_due  = (rcnt_q == RC_LAST);
  wire        rot_take = rot_due & ~mode_inject & trng_valid;
  wire [2:0]  step     = trng_bit ? 3'd2 : 3'd1;
  wire        word_end = (scnt_q == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEED_FALLBACK;
      pos_q      <= '0;
      rcnt_q     <= '0;
      scnt_q     <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else if (seed_load) begin
      state_q    <= (seed == '0) ? SEED_FALLBACK : seed;
      pos_q      <= '0;
      rcnt_q     <= '0;
      scnt_q     <= '0;
      word_valid <= 1'b0;
    end else if (shift_en) begin
      state_q    <= state_nx;
      rcnt_q     <= rot_due ? '0 : rcnt_q + 1'b1;
      scnt_q     <= scnt_q + 1'b1;
      word_valid <= word_end;
      if (rot_take) pos_q <= pos_q + step;
      if (word_end) word_out <= state_nx;
    end else begin
      word_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trng_mp_lfsr_chk.sv
module trng_mp_lfsr_chk #(
  parameter int          ROT_PERIOD    = 4,
  parameter logic [15:0] SEED_FALLBACK = 16'hACE1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        seed_load,
  input logic [15:0] seed,
  input logic        trng_bit,
  input logic        trng_valid,
  input logic        run,
  input logic        mode_inject,
  input logic        word_valid,
  input logic [15:0] state,
  input logic [2:0]  pos
);
  localparam int RCW = (ROT_PERIOD > 1) ? $clog2(ROT_PERIOD) : 1;

  logic [3:0]     c_shift;
  logic [RCW-1:0] c_rot;
  logic           exp_valid, rot_q, load_q;
  logic [2:0]     step_q;

  wire sh = run & ~seed_load;
  wire due = (c_rot == RCW'(ROT_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_shift <= '0; c_rot <= '0; exp_valid <= 1'b0;
      rot_q <= 1'b0; step_q <= '0; load_q <= 1'b0;
    end else begin
      load_q    <= seed_load;
      exp_valid <= sh && (c_shift == 4'd15);
      rot_q     <= sh && due && trng_valid && !mode_inject;
      step_q    <= trng_bit ? 3'd2 : 3'd1;
      if (seed_load) begin
        c_shift <= '0; c_rot <= '0;
      end else if (sh) begin
        c_shift <= c_shift + 1'b1;
        c_rot   <= due ? '0 : c_rot + 1'b1;
      end
    end
  end

  AST_WORD_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid == exp_valid); // R4

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (state == ($past(seed) == 16'h0 ? SEED_FALLBACK : $past(seed))) && pos == 3'd0); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !seed_load) |=> $stable(state) && $stable(pos) && !word_valid); // R5

  AST_WHEEL_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> (pos == (rot_q ? 3'($past(pos) + step_q) : $past(pos)))); // R6 R8

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rot_q |-> pos != $past(pos)); // R7

  AST_INJECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_inject && !seed_load) |=> $stable(pos)); // R9
endmodule

bind trng_mp_lfsr trng_mp_lfsr_chk #(.ROT_PERIOD(ROT_PERIOD), .SEED_FALLBACK(SEED_FALLBACK)) chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
  .trng_bit(trng_bit), .trng_valid(trng_valid), .run(run),
  .mode_inject(mode_inject), .word_valid(word_valid),
  .state(state_q), .pos(pos_q)
);

// File: tb/trng_mp_lfsr_test.sv
module trng_mp_lfsr_test;
  localparam int ROT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seed_load = 1'b0, trng_bit = 1'b0, trng_valid = 1'b0, run = 1'b0, mode_inject = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] word_out;
  logic word_valid;

  int checks = 0, fails = 0, cycles = 0;

  logic [15:0] m_state, exp_w;
  logic [2:0]  m_pos;
  int          m_r, m_s;
  logic        exp_v;

  always #5 clk = ~clk;

  trng_mp_lfsr #(.ROT_PERIOD(ROT)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .trng_bit(trng_bit), .trng_valid(trng_valid), .run(run),
    .mode_inject(mode_inject), .word_out(word_out), .word_valid(word_valid)
  );

  function automatic logic [15:0] mask(input logic [2:0] i);
    logic [15:0] t [8] = '{16'hB400, 16'hD008, 16'h8016, 16'h8805,
                            16'h801C, 16'h9C00, 16'h8068, 16'h8B00};
    return t[i];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic ld, input logic [15:0] sd,
                      input logic tb, input logic tv, input logic mi, input string tag);
    logic f;
    logic [15:0] ns;
    run = r; seed_load = ld; seed = sd; trng_bit = tb; trng_valid = tv; mode_inject = mi;
    @(posedge clk);
    if (ld) begin
      m_state = (sd == 16'h0) ? 16'hACE1 : sd;
      m_pos = 3'd0; m_r = 0; m_s = 0; exp_v = 1'b0;
    end else if (r) begin
      f  = (^(m_state & mask(m_pos))) ^ (mi & tv & tb);
      ns = {m_state[14:0], f};
      if (m_r == ROT - 1) begin
        m_r = 0;
        if (!mi && tv) m_pos = m_pos + (tb ? 3'd2 : 3'd1);
      end else m_r++;
      m_state = ns;
      if (m_s == 15) begin m_s = 0; exp_v = 1'b1; exp_w = ns; end
      else begin m_s++; exp_v = 1'b0; end
    end else exp_v = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, {15'h0, word_valid}, {15'h0, exp_v});
    check({tag, " word"}, word_out, exp_w);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned s0;
    s0 = $urandom(32'h5EED_1234);
    m_state = 16'hACE1; m_pos = 0; m_r = 0; m_s = 0; exp_v = 0; exp_w = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {15'h0, word_valid}, 16'h0);
    check("R1 reset word", word_out, 16'h0);
    rst_n = 1'b1;
    // R1 R3: first word from the reset value on slot 0
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, "R1_R3 reset-seed");
    // R2: zero seed falls back, load wins over run
    step(1, 1, 16'h0, 0, 0, 0, "R2 zero seed");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, "R2 fallback word");
    step(1, 1, 16'h1357, 1, 1, 0, "R2 seed");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, 1, 0, "R6_R7 step-two");
    step(1, 1, 16'h8001, 0, 1, 0, "R2 reload mid-word");
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 1, 0, "R6_R7 step-one");
    // R8: no entropy, wheel stays on slot 0
    step(1, 1, 16'hFFFF, 0, 0, 0, "R2 seed");
    for (int i = 0; i < 48; i++) step(1, 0, 0, $urandom % 2, 0, 0, "R8 starved");
    // R5: idle gaps
    for (int i = 0; i < 200; i++) step($urandom % 3 != 0, 0, 0, $urandom % 2, 1, 0, "R5 gaps");
    // R9: injection mode
    step(1, 1, 16'h0F0F, 0, 0, 1, "R2 seed");
    for (int i = 0; i < 64; i++) step(1, 0, 0, $urandom % 2, $urandom % 2, 1, "R9 inject");
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step($urandom % 8 != 0, $urandom % 97 == 0, 16'($urandom % 4 == 0 ? 0 : $urandom),
           $urandom % 2, $urandom % 4 != 0, $urandom % 5 == 0, "R4_R6_R7 random");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule